// File: doc/BRIEF.md
# Banked Video Memory Host Port

This block is the host-facing access port of a video controller. A host issues accesses with a byte address, an access size, a read/write strobe and write data. The port steers each access to one of three places. The first is a 16-bit word memory made of two equal banks. The second is a 16-word control register window that can be moved to another word base. The third is a write-only palette that fills its 16 entries one after another through a single address.

The control registers live in the first 16 words of bank 0. The window is only a second, movable way to reach them. Two register fields steer the port: one sets the window base, the other sets the active bank. Changes to either field have no effect until the next frame-start pulse. This lets the host reprogram the map in the middle of a frame without disturbing accesses that are already in flight. Illegal accesses change nothing and raise an error flag.

The bank depth is a parameter. A depth exponent of 16 gives the full 0x10000 words per bank. The default is a small depth, so that elaboration stays cheap.

Top module: `vmp_host_port`

## Requirements
- R1: An access is legal only when `acc_size` is 2 (a 16-bit word) and `acc_addr[0]` is 0. An illegal access sets `acc_err` to 1 in the following cycle, changes no memory, register, palette entry or palette index, and gives `rd_data` = 0.
- R2: A legal memory access outside the window uses word index `acc_addr >> 1` and reaches word `bank * DEPTH + index`, where DEPTH is `2**BANK_AW`.
- R3: After reset the window base is word 0x200. On each `frame_start` cycle the base reloads as `(register 2 & 0xFFF0) << 1`. At all other times it holds.
- R4: A word index in `[base, base+16)` reaches register `index - base`, and this takes priority over the memory array. Register n is the same storage as bank 0 word n.
- R5: On each `frame_start` cycle the bank reloads from register 5: bank bit 0 comes from bit 8 and bank bit 1 comes from bit 7. The bank is 0 after reset. While the bank is 2 or 3, every access is illegal.
- R6: A legal write to word index `PAL_WORD` (default 0x40000, which is byte address 0x80000) stores the data into the palette entry at the current index. The index then advances modulo 16. The index starts at 0, and every entry starts at 0. `pal_color` shows the entry chosen by `pal_sel`.
- R7: A read at a word index of DEPTH or above is illegal. A write at a word index of DEPTH or above is illegal unless the index is `PAL_WORD`.
- R8: A write takes effect at the clock edge of its strobe. Read data and the error flag appear in the next cycle. An access in a `frame_start` cycle uses the old bank and base. The reload uses register values from before any write made in that same cycle.
- R9: `rd_data` is 0 in every cycle that does not follow a legal read, and `acc_err` is 0 after a cycle without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse that reloads the bank and the window base |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | Access size in bytes; only 2 is legal |
| acc_addr | input | ADDR_W (20) | Byte address |
| acc_wdata | input | 16 | Write data |
| rd_data | output | 16 | Read data, one cycle after the strobe |
| acc_err | output | 1 | Illegal-access flag, one cycle after the strobe |
| pal_sel | input | 4 | Palette entry to show |
| pal_color | output | 16 | Palette entry chosen by `pal_sel` |

## Verification
An access and a frame-start pulse can fall in the same cycle. The hardest case is a host write to register 2 or register 5 in that same cycle. The bench drives exactly this collision on purpose, and it also mixes random frame pulses into random traffic. A behavioural reference model judges every cycle. In that model the reload reads the register values from before the write, and the access itself decodes with the old bank and base. A later read inside the old and the new window positions then shows which mapping took effect.

// File: rtl/vmp_pkg.sv
// Package: shared constants and types for the banked video memory host port.
// Assumes 16-bit data words and a 16-word register window.
package vmp_pkg;
    localparam int          WORD_BITS    = 16;
    localparam int          REG_WORDS    = 16;
    localparam int          REG_BASE_IDX = 2;
    localparam int          REG_BANK_IDX = 5;
    localparam int          BASE_BITS    = 17;
    localparam logic [1:0]  SIZE_HALF    = 2'd2;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_MEM  = 2'd1,
        TGT_PAL  = 2'd2
    } target_e;
endpackage

// File: rtl/vmp_decode.sv
// Module: vmp_decode
// Combinational decode of one host access. It checks legality, picks the
// target, and forms the memory word index. The window takes priority over
// the bank array.
// Assumes: the base is a multiple of 32, so its low 5 bits are zero, and BANK_AW >= 4.
module vmp_decode
    import vmp_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int BANK_AW  = 10,
    parameter int PAL_WORD = 'h40000
) (
    input  logic                  valid,
    input  logic                  write,
    input  logic [1:0]            size,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [1:0]            bank,
    input  logic [BASE_BITS-1:0]  base,
    output target_e               target,
    output logic [BANK_AW:0]      mem_idx,
    output logic                  err
);
    localparam int WIDX_W = ADDR_W - 1;
    localparam int RW_AW  = $clog2(REG_WORDS);
    localparam logic [WIDX_W-1:0] DEPTH_IDX = WIDX_W'(1 << BANK_AW);
    localparam logic [WIDX_W-1:0] PAL_IDX   = WIDX_W'(PAL_WORD);

    logic [WIDX_W-1:0] word, base_ext, win_end;
    logic [RW_AW-1:0]  win_off;
    logic              in_win, above, bad;

    // Purpose: split the address and classify it against the window and the bank depth.
    always_comb begin
        word     = addr[ADDR_W-1:1];
        base_ext = WIDX_W'(base);
        win_end  = base_ext + WIDX_W'(REG_WORDS);
        in_win   = (word >= base_ext) && (word < win_end);
        above    = word >= DEPTH_IDX;
        win_off  = word[RW_AW-1:0] - base[RW_AW-1:0];
        bad      = (size != SIZE_HALF) || addr[0] || bank[1] ||
                   (above && !(write && word == PAL_IDX));
        err      = valid && bad;
        if (!valid || bad) target = TGT_NONE;
        else if (above)    target = TGT_PAL;
        else               target = TGT_MEM;
        mem_idx  = in_win ? (BANK_AW + 1)'(win_off) : {bank[0], word[BANK_AW-1:0]};
    end
endmodule

// File: rtl/vmp_frame_latch.sv
// Module: vmp_frame_latch
// Holds the active bank and the window base. Both reload only on frame_start,
// from the register fields they are given.
// Assumes: the fields come from register contents before any write in the same cycle.
module vmp_frame_latch
    import vmp_pkg::*;
#(
    parameter int BASE_RESET = 'h200
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_start,
    input  logic [1:0]            bank_bits,
    input  logic [11:0]           base_field,
    output logic [1:0]            bank,
    output logic [BASE_BITS-1:0]  base
);
    // Purpose: latch the bank and the base at frame start, and hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank <= 2'd0;
            base <= BASE_BITS'(BASE_RESET);
        end else if (frame_start) begin
            bank <= bank_bits;
            base <= {base_field, 5'd0};
        end
    end

    assert_map_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(bank) && $stable(base)));
    assert_base_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        base[4:0] == 5'd0);
    assert_bank_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (bank == $past(bank_bits)));
endmodule

// File: rtl/vmp_palette.sv
// Module: vmp_palette
// Write-only palette with an auto-incrementing write index. Entries are
// shown to the display side through a select input.
// Assumes: wr is asserted only for legal palette writes.
module vmp_palette #(
    parameter int ENTRIES = 16,
    parameter int DW      = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr,
    input  logic [DW-1:0]               wdata,
    input  logic [$clog2(ENTRIES)-1:0]  sel,
    output logic [DW-1:0]               color
);
    localparam int IW = $clog2(ENTRIES);
    localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

    logic [DW-1:0] entry [ENTRIES];
    logic [IW-1:0] idx;

    // Purpose: store at the current index and advance it with wrap-around.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
            for (int i = 0; i < ENTRIES; i++) entry[i] <= '0;
        end else if (wr) begin
            entry[idx] <= wdata;
            idx        <= (idx == LAST) ? '0 : idx + 1'b1;
        end
    end

    // Purpose: show the selected entry to the display side.
    always_comb color = entry[sel];

    assert_idx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(idx));
    assert_idx_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (idx != $past(idx)));
endmodule

// File: rtl/vmp_host_port.sv
// Module: vmp_host_port (top)
// Host access port of a video controller. It serves a two-bank word memory,
// a movable 16-word register window that aliases bank 0 words 0..15, and a
// sequential palette port.
// Assumes: single-cycle strobes; reads return registered data one cycle later.
module vmp_host_port
    import vmp_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int BANK_AW     = 10,
    parameter int PAL_WORD    = 'h40000,
    parameter int PAL_ENTRIES = 16,
    parameter int BASE_RESET  = 'h200
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            frame_start,
    input  logic                            acc_valid,
    input  logic                            acc_write,
    input  logic [1:0]                      acc_size,
    input  logic [ADDR_W-1:0]               acc_addr,
    input  logic [WORD_BITS-1:0]            acc_wdata,
    output logic [WORD_BITS-1:0]            rd_data,
    output logic                            acc_err,
    input  logic [$clog2(PAL_ENTRIES)-1:0]  pal_sel,
    output logic [WORD_BITS-1:0]            pal_color
);
    localparam int MEM_WORDS = 2 ** (BANK_AW + 1);

    logic [WORD_BITS-1:0] mem [MEM_WORDS];
    logic [1:0]           bank;
    logic [BASE_BITS-1:0] base;
    target_e              target;
    logic [BANK_AW:0]     mem_idx;
    logic                 dec_err;

    vmp_decode #(.ADDR_W(ADDR_W), .BANK_AW(BANK_AW), .PAL_WORD(PAL_WORD)) u_decode (
        .valid (acc_valid), .write (acc_write), .size (acc_size), .addr (acc_addr),
        .bank  (bank), .base (base), .target (target), .mem_idx (mem_idx), .err (dec_err)
    );

    vmp_frame_latch #(.BASE_RESET(BASE_RESET)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .bank_bits  ({mem[REG_BANK_IDX][7], mem[REG_BANK_IDX][8]}),
        .base_field (mem[REG_BASE_IDX][15:4]),
        .bank       (bank),
        .base       (base)
    );

    vmp_palette #(.ENTRIES(PAL_ENTRIES), .DW(WORD_BITS)) u_palette (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (target == TGT_PAL && acc_write),
        .wdata (acc_wdata),
        .sel   (pal_sel),
        .color (pal_color)
    );

    // Purpose: write the memory array on a legal memory write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_WORDS; i++) mem[i] <= '0;
        end else if (target == TGT_MEM && acc_write) begin
            mem[mem_idx] <= acc_wdata;
        end
    end

    // Purpose: register the read data and the error flag for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            acc_err <= 1'b0;
        end else begin
            rd_data <= (target == TGT_MEM && !acc_write) ? mem[mem_idx] : '0;
            acc_err <= dec_err;
        end
    end

    assert_bad_size_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_size != SIZE_HALF) |=> acc_err);
    assert_odd_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_addr[0]) |=> (acc_err && rd_data == '0));
    assert_locked_bank_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && bank[1]) |=> acc_err);
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (!acc_err && rd_data == '0));
    assert_write_no_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write) |=> (rd_data == '0));
endmodule

// File: tb/tb_vmp_host_port.sv
`timescale 1ns/1ps
module tb_vmp_host_port;
    localparam int D    = 1024;
    localparam int PALW = 'h40000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [1:0]  acc_size = 2'd2;
    logic [19:0] acc_addr = '0;
    logic [15:0] acc_wdata = '0;
    logic [15:0] rd_data;
    logic        acc_err;
    logic [3:0]  pal_sel = '0;
    logic [15:0] pal_color;

    int checks = 0;
    int fails  = 0;

    // Reference model state
    logic [15:0] m_mem [2*D];
    logic [15:0] m_pal [16];
    int m_pi, m_bank, m_base;

    always #10 clk = ~clk;

    vmp_host_port dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .acc_valid(acc_valid),
        .acc_write(acc_write), .acc_size(acc_size), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .rd_data(rd_data), .acc_err(acc_err),
        .pal_sel(pal_sel), .pal_color(pal_color)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 2*D; i++) m_mem[i] = '0;
        for (int i = 0; i < 16; i++) m_pal[i] = '0;
        m_pi = 0; m_bank = 0; m_base = 'h200;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; acc_valid = 1'b0; frame_start = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R9 reset rd_data", rd_data, 0);
        chk("R9 reset acc_err", acc_err, 0);
        chk("R6 reset pal_color", pal_color, 0);
    endtask

    // One cycle: drive at negedge, predict, clock, check at the next negedge.
    task automatic step(input bit v, input bit w, input logic [1:0] sz, input logic [19:0] a,
                        input logic [15:0] d, input bit fs, input logic [3:0] ps, input string tag);
        int word, ix, r2, r5;
        bit ill;
        int e_rd;
        acc_valid = v; acc_write = w; acc_size = sz; acc_addr = a; acc_wdata = d;
        frame_start = fs; pal_sel = ps;
        word = int'(a) >> 1;
        r2 = m_mem[2]; r5 = m_mem[5];
        ill = v && (sz != 2 || a[0] || m_bank >= 2 || (word >= D && !(w && word == PALW)));
        e_rd = 0;
        if (v && !ill) begin
            if (word >= D) begin
                m_pal[m_pi] = d;
                m_pi = (m_pi + 1) % 16;
            end else begin
                if (word >= m_base && word < m_base + 16) ix = word - m_base;
                else ix = m_bank * D + word;
                if (w) m_mem[ix] = d;
                else e_rd = m_mem[ix];
            end
        end
        if (fs) begin
            m_bank = ((r5 >> 8) & 1) + 2 * ((r5 >> 7) & 1);
            m_base = (r2 & 'hFFF0) << 1;
        end
        @(posedge clk);
        @(negedge clk);
        acc_valid = 1'b0; frame_start = 1'b0;
        chk({tag, " rd_data"}, rd_data, e_rd);
        chk({tag, " acc_err"}, acc_err, int'(ill));
        chk({tag, " pal_color"}, pal_color, m_pal[ps]);
    endtask

    function automatic logic [19:0] wb(input int word);
        return 20'(word * 2);
    endfunction

    initial begin : watchdog
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        do_reset();
        // R2: bank 0 plain memory
        step(1, 1, 2, wb('h100), 16'hA5A5, 0, 0, "R2 wr b0");
        step(1, 0, 2, wb('h100), 0, 0, 0, "R2 rd b0");
        step(1, 0, 2, wb('h3FF), 0, 0, 0, "R2 rd top");
        // R4: window at 0x200 reaches registers; alias with bank 0 words
        step(1, 1, 2, wb('h203), 16'h1234, 0, 0, "R4 win wr r3");
        step(1, 0, 2, wb('h003), 0, 0, 0, "R4 alias rd");
        step(1, 1, 2, wb('h00A), 16'h5555, 0, 0, "R4 alias wr");
        step(1, 0, 2, wb('h20A), 0, 0, 0, "R4 win rd r10");
        // R3: program base, no effect before frame
        step(1, 1, 2, wb('h202), 16'h0150, 0, 0, "R3 wr r2");
        step(1, 0, 2, wb('h202), 0, 0, 0, "R3 base held");
        // R8: write r5 (bank 1) in the frame cycle -> reload sees old r5 (0)
        step(1, 1, 2, wb('h205), 16'h0100, 1, 0, "R8 collide");
        step(1, 0, 2, wb('h2A5), 0, 0, 0, "R3 new base");
        step(1, 0, 2, wb('h205), 0, 0, 0, "R3 old base gone");
        step(1, 1, 2, wb('h110), 16'hBEEF, 0, 0, "R5 still b0");
        step(0, 0, 2, 0, 0, 1, 0, "R5 frame to b1");
        step(1, 0, 2, wb('h110), 0, 0, 0, "R5 b1 read");
        step(1, 1, 2, wb('h110), 16'hC0DE, 0, 0, "R2 wr b1");
        step(1, 1, 2, wb('h2A3), 16'h7777, 0, 0, "R4 prio wr");
        step(1, 0, 2, wb('h003), 0, 0, 0, "R4 reg via alias");
        // move window to 0 and check bank 1 word 0x2A3 untouched
        step(1, 1, 2, wb('h2A2), 16'h0000, 1, 0, "R8 base wr+frame");
        step(0, 0, 2, 0, 0, 1, 0, "R3 frame to base0");
        step(1, 0, 2, wb('h2A3), 0, 0, 0, "R4 prio mem untouched");
        step(1, 0, 2, wb('h005), 0, 0, 0, "R4 base0 r5");
        // R1 / R7 illegal accesses
        step(1, 1, 1, wb('h120), 16'h1111, 0, 0, "R1 size1 wr");
        step(1, 0, 3, wb('h110), 0, 0, 0, "R1 size3 rd");
        step(1, 1, 2, wb('h120) | 1, 16'h2222, 0, 0, "R1 odd wr");
        step(1, 0, 2, wb('h120), 0, 0, 0, "R1 no effect");
        step(1, 0, 2, wb(D), 0, 0, 0, "R7 rd above");
        step(1, 1, 2, wb(D + 1), 16'h3333, 0, 0, "R7 wr above");
        step(1, 0, 2, wb(PALW), 0, 0, 0, "R7 rd pal");
        // R6 palette sequence and wrap
        for (int i = 0; i < 18; i++)
            step(1, 1, 2, wb(PALW), 16'(16'h0F00 + i), 0, 4'(i), "R6 pal wr");
        for (int i = 0; i < 16; i++)
            step(0, 0, 2, 0, 0, 0, 4'(i), "R6 pal view");
        step(1, 1, 2, wb(PALW) | 1, 16'hDEAD, 0, 1, "R1 pal odd");
        step(1, 1, 2, wb(PALW), 16'h0ABC, 0, 2, "R6 idx after bad");
        // random traffic with frame pulses
        for (int n = 0; n < 600; n++) begin
            int sel, word;
            logic [1:0] sz;
            sel = $urandom_range(0, 9);
            if (sel < 4)      word = $urandom_range(0, D - 1);
            else if (sel < 8) word = m_base + $urandom_range(0, 15);
            else if (sel < 9) word = PALW;
            else              word = $urandom_range(D, D + 40);
            sz = ($urandom_range(0, 15) == 0) ? 2'd1 : 2'd2;
            step($urandom_range(0, 4) != 0, $urandom_range(0, 1) == 1, sz,
                 wb(word) | 20'($urandom_range(0, 19) == 0),
                 16'($urandom_range(0, 65535) & 16'hFE7F), $urandom_range(0, 20) == 0,
                 4'($urandom_range(0, 15)), "R8 random");
        end
        // R5: lock with bank 2 (bit 7 set) and check all accesses refused
        step(1, 1, 2, wb(m_base + 5), 16'h0080, 0, 0, "R5 set b2");
        step(0, 0, 2, 0, 0, 1, 0, "R5 frame b2");
        step(1, 0, 2, wb('h010), 0, 0, 0, "R5 locked rd");
        step(1, 1, 2, wb(PALW), 16'h4444, 0, 0, "R5 locked pal");
        do_reset();
        step(1, 0, 2, wb('h200), 0, 0, 0, "R3 reset base");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule